// File: doc/BRIEF.md
# Serial Pattern Recognizer With Lockout

This block watches a one-bit serial stream, taking one bit on every rising clock edge. It raises a one-bit flag whenever the three most recent bits are 0, 1 and 0 in that order. Matches may overlap, so the final 0 of one match can also be the first 0 of the next one.

The block also watches for the triple 1, 0, 0. Once that triple has appeared anywhere since the last reset, the block falls into a sticky lockout. In lockout it never raises the flag again, whatever comes in, until the next reset. Reset is synchronous and active high.

The recogniser is a Moore machine with seven states. Each state has a fixed code, and the flag is one bit of the state register, so the output is registered and cannot glitch. The flag is valid in the cycle after the edge that samples the third bit of a match.

Top module: `serial_match_lockout`

## Requirements
- R1: While reset is high at a clock edge, the machine goes to a start state that holds no history, and the flag reads 0 after that edge.
- R2: The flag is 1 in the cycle after the edge that samples a 0 which completes the bit order 0, 1, 0, provided the triple 1, 0, 0 has not occurred since reset. In every other cycle the flag is 0.
- R3: Matches overlap. From a match, the further input 1 then 0 gives a new match two edges later.
- R4: After the triple 1, 0, 0 has been sampled, the flag stays 0 for any later input until reset. The bench checks this at the flag by driving further 0, 1, 0 orders during lockout.
- R5: Runs of repeated 0s, or of repeated 1s, never raise the flag. A run of 0s followed by 1, 0 does raise it.
- R6: A reset in the middle of a stream clears the history and the lockout, including from the lockout state. Detection then restarts from zero bits.
- R7: Fewer than three bits sampled since reset never raise the flag.
- R8: The input 0,0,1,0,1,0,1,0,0,1,0 after reset gives the flag values 0,0,0,1,0,1,0,1,0,0,0, one per edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| data_i | input | 1 | Serial bit, sampled every rising edge |
| match_o | output | 1 | Registered flag: last three bits were 0,1,0 and no lockout |

## Verification
The hardest behaviour to reach from the ports is a long run of overlapping matches without lockout. A uniformly random stream produces the triple 1,0,0 within a few bits, so it spends almost all of its time locked.

To get past this, the stimulus is split into short segments, each opened with a reset. Some segments are unbiased. Others never follow 1,0 with a 0, so they stay unlocked for their whole length and chain many matches. Others are heavy in 1s.

Directed sequences cover three further cases: a reset issued from the lockout state, lockout reached directly from a match, and matches attempted during lockout.

// File: rtl/serial_match_pkg.sv
package serial_match_pkg;

    localparam int unsigned ST_W = 4;

    // Bit 0 of each code is the output flag; only the match state sets it.
    typedef enum logic [ST_W-1:0] {
        ST_EMPTY  = 4'b0000,
        ST_TAIL0  = 4'b0010,
        ST_TAIL1  = 4'b0100,
        ST_TAIL01 = 4'b0110,
        ST_TAIL10 = 4'b1000,
        ST_LOCK   = 4'b1010,
        ST_MATCH  = 4'b0111
    } rec_state_e;

    typedef struct packed {
        rec_state_e state;
    } rec_regs_t;

    localparam rec_regs_t REC_RESET = '{state: ST_EMPTY};

endpackage

// File: rtl/serial_match_next.sv
module serial_match_next
    import serial_match_pkg::*;
(
    input  rec_regs_t regs_q,
    input  logic      rst_i,
    input  logic      data_i,
    output rec_regs_t regs_d
);

    always_comb begin
        regs_d = regs_q;
        if (rst_i) begin
            regs_d = REC_RESET;
        end else begin
            unique case (regs_q.state)
                ST_EMPTY:  regs_d.state = data_i ? ST_TAIL1  : ST_TAIL0;
                ST_TAIL0:  regs_d.state = data_i ? ST_TAIL01 : ST_TAIL0;
                ST_TAIL01: regs_d.state = data_i ? ST_TAIL1  : ST_MATCH;
                ST_MATCH:  regs_d.state = data_i ? ST_TAIL01 : ST_LOCK;
                ST_TAIL1:  regs_d.state = data_i ? ST_TAIL1  : ST_TAIL10;
                ST_TAIL10: regs_d.state = data_i ? ST_TAIL01 : ST_LOCK;
                ST_LOCK:   regs_d.state = ST_LOCK;
                default:   regs_d.state = ST_EMPTY;
            endcase
        end
    end

endmodule

// File: rtl/serial_match_reg.sv
module serial_match_reg
    import serial_match_pkg::*;
(
    input  logic      clk_i,
    input  rec_regs_t regs_d,
    output rec_regs_t regs_q
);

    always_ff @(posedge clk_i) begin
        regs_q <= regs_d;
    end

endmodule

// File: rtl/serial_match_lockout.sv
module serial_match_lockout
    import serial_match_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic data_i,
    output logic match_o
);

    rec_regs_t regs_d;
    rec_regs_t regs_q;

    serial_match_next next_i (
        .regs_q (regs_q),
        .rst_i  (rst_i),
        .data_i (data_i),
        .regs_d (regs_d)
    );

    serial_match_reg reg_i (
        .clk_i  (clk_i),
        .regs_d (regs_d),
        .regs_q (regs_q)
    );

    // Flag taken straight from the state register.
    assign match_o = regs_q.state[0];

    assert_reset_clears_R1: assert property (@(posedge clk_i)
        rst_i |=> (regs_q.state == ST_EMPTY && !match_o))
        else $error("R1 reset did not clear");

    assert_match_needs_zero_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (match_o && !$past(rst_i)) |-> !$past(data_i))
        else $error("R2 flag without a final 0");

    assert_overlap_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (regs_q.state == ST_MATCH && data_i) |=> (regs_q.state == ST_TAIL01))
        else $error("R3 overlap path broken");

    assert_lock_entry_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (regs_q.state == ST_MATCH && !data_i) |=> (regs_q.state == ST_LOCK))
        else $error("R4 lockout not entered");

    assert_lock_sticky_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (regs_q.state == ST_LOCK) |=> (regs_q.state == ST_LOCK && !match_o))
        else $error("R4 lockout left without reset");

    assert_first_bits_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (regs_q.state == ST_EMPTY) |=> !match_o)
        else $error("R7 flag after one bit");

endmodule

// File: tb/serial_match_lockout_tb_top.sv
`timescale 1ns/1ps
module serial_match_lockout_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic data = 1'b0;
    logic match;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit    exp_q[$];
    string tag_q[$];

    // reference model
    logic [2:0] hist = 3'b000;
    int         nbits = 0;
    bit         locked = 1'b0;

    always #2.5 clk = ~clk;

    serial_match_lockout dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .data_i  (data),
        .match_o (match)
    );

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst  = 1'b1;
        data = 1'($urandom);
        hist = 3'b000;
        nbits = 0;
        locked = 1'b0;
        exp_q.push_back(1'b0);
        tag_q.push_back(tag);
    endtask

    task automatic push_bit(input bit b, input string tag);
        bit e;
        @(negedge clk);
        rst  = 1'b0;
        data = b;
        hist = {hist[1:0], b};
        if (nbits < 3) nbits++;
        if (nbits == 3 && hist == 3'b100) locked = 1'b1;
        e = (nbits == 3 && hist == 3'b010 && !locked);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic push_vec(input logic [31:0] v, input int n, input string tag);
        for (int i = n - 1; i >= 0; i--) push_bit(v[i], tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                bit    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (match !== e) begin
                    errors++;
                    $display("FAIL %s actual=%b expected=%b at %0t", t, match, e, $time);
                end
            end
        end
    end

    // watchdog
    initial begin
        #500000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset("R1");
        do_reset("R1");
        // R8 fixed example
        push_vec(32'b00101010010, 11, "R8");
        // R4 matches attempted during lockout
        push_vec(32'b010010, 6, "R4");
        // R6 reset from lockout, then detection restarts
        do_reset("R6");
        push_vec(32'b010, 3, "R6");
        // R7 fewer than three bits
        do_reset("R7");
        push_vec(32'b10, 2, "R7");
        do_reset("R7");
        push_vec(32'b01, 2, "R7");
        // R5 runs
        do_reset("R5");
        push_vec(32'b00000000, 8, "R5");
        push_vec(32'b10, 2, "R5");
        do_reset("R5");
        push_vec(32'b11111111, 8, "R5");
        // R3 overlapping chain, then lockout straight from a match
        do_reset("R3");
        push_vec(32'b0101010101, 10, "R3");
        push_vec(32'b0010, 4, "R4");
        // R6 reset in the middle of a partial match
        do_reset("R6");
        push_vec(32'b01, 2, "R6");
        do_reset("R6");
        push_vec(32'b0, 1, "R6");
        // random segments
        for (int seg = 0; seg < 250; seg++) begin
            do_reset("R6");
            for (int k = 0; k < 40; k++) begin
                bit b;
                case (seg % 3)
                    0: b = 1'($urandom);
                    1: b = (hist[1:0] == 2'b10 && nbits >= 2) ? 1'b1 : 1'($urandom);
                    default: b = (($urandom % 4) != 0);
                endcase
                push_bit(b, "R2");
            end
        end
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule